// File: doc/BRIEF.md
# Fractional Line Interrupt Scheduler

This block produces a periodic horizontal line interrupt for a secondary processor. Time is counted in main-CPU cycles, and one video line lasts 488.5 of them. The half cycle cannot be dropped without drift, so the block carries it in a fixed-point accumulator with four fractional bits. Each period is computed from a programmable line count. The whole-cycle part is loaded into a down-counter, and the residue stays behind for the next period. Over a long run, consecutive line periods therefore alternate between 488 and 489 cycles.

When vertical blank ends and interrupts are not allowed during blank, the scheduler restarts with a negative offset of one and a half cycles. This pulls the first line interrupt of the frame slightly earlier, so it lands ahead of the vertical interrupt with margin. While interrupts are not allowed during blank and blank is active, an expiring countdown still fires its pulse, but no new period is queued.

Top module: `line_irq_sched`

## Requirements
- R1: After reset, `irq` is 0 and `countdown` is 0. Both stay there under any number of ticks until a schedule is started by `vblank_end`.
- R2: A reschedule adds (`line_cfg` + 1) × 7816 to the base value, where 7816 is 488.5 in units of 1/16 cycle. The base is the kept residue (0..15), or −24 at a blank-end restart. `countdown` is loaded with the sum divided by 16, and the remainder becomes the new residue.
- R3: With `line_cfg` = 0 and a residue of 0, two consecutive periods load 488 and then 489.
- R4: `vblank_end` with `hint_in_vblank` = 0 uses base −24 and discards any kept residue. The new countdown appears on the next clock edge, whether or not a countdown was already running. With `line_cfg` = 0 this gives 487.
- R5: `vblank_end` with `hint_in_vblank` = 1 is ignored while a countdown is running, and the countdown keeps decrementing. When the block is idle, it starts a period from the kept residue without the −24 offset.
- R6: While a countdown runs, each cycle with `tick` = 1 lowers `countdown` by one, and a cycle with `tick` = 0 leaves it unchanged.
- R7: A tick while `countdown` is 1 raises `irq` for exactly one cycle after the next edge. On that same edge `countdown` reloads with the next period.
- R8: If that expiry happens with `hint_in_vblank` = 0 and `vblank` = 1, `irq` still pulses, but `countdown` goes to 0. No further pulse occurs until the next `vblank_end`.
- R9: A change of `line_cfg` does not affect a running countdown. It takes effect at the next reschedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_cfg | input | LINE_W | Lines per interrupt, minus one |
| vblank_end | input | 1 | One-cycle strobe at the end of vertical blank |
| hint_in_vblank | input | 1 | 1 = line interrupts allowed during blank |
| vblank | input | 1 | Vertical blank active |
| tick | input | 1 | One main-CPU cycle has elapsed |
| irq | output | 1 | One-cycle line interrupt pulse |
| countdown | output | CNT_W | Ticks remaining to the next interrupt (0 = idle) |

## Verification
The case that is hardest to reach is the fractional carry. The 488/489 alternation only shows after several expiries have passed with a known residue. A blank-end restart wipes that residue, so any later value depends on the whole history since the last restart. Directed sequences drive the counter through full periods, changing `line_cfg` mid-count and forcing suppressed expiries and idle restarts. After that, a long randomized run with sparse ticks and random blank events is compared cycle by cycle against a bench model.

// File: rtl/lis_pkg.sv
package lis_pkg;
  localparam int FRAC_BITS = 4;
  // Blank-end preload: -1.5 cycles in Q4
  localparam int BLANK_PRELOAD_Q4 = -24;

  typedef logic signed [31:0] q4_t;

  // base + (lines_m1 + 1) * line_q4, all in Q4
  function automatic q4_t period_add(input q4_t base, input int unsigned lines_m1,
                                     input int unsigned line_q4);
    period_add = base + q4_t'((lines_m1 + 32'd1) * line_q4);
  endfunction

  // Whole-cycle part of a Q4 value
  function automatic q4_t whole_part(input q4_t v);
    whole_part = v >>> FRAC_BITS;
  endfunction
endpackage

// File: rtl/lis_ctrl.sv
module lis_ctrl (
  input  logic vblank_end,
  input  logic hint_in_vblank,
  input  logic vblank,
  input  logic armed,
  input  logic expire,
  output logic preload,
  output logic sched,
  output logic stop
);
  logic idle_start;
  logic suppress;

  always_comb begin
    preload    = vblank_end & ~hint_in_vblank;
    idle_start = vblank_end & hint_in_vblank & ~armed;
    suppress   = ~hint_in_vblank & vblank;
    sched      = preload | idle_start | (expire & ~suppress);
    stop       = expire & ~sched;
  end
endmodule

// File: rtl/lis_accum.sv
module lis_accum import lis_pkg::*; #(
  parameter int LINE_W  = 8,
  parameter int LINE_Q4 = 7816,
  parameter int CNT_W   = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sched,
  input  logic              preload,
  input  logic [LINE_W-1:0] line_cfg,
  output logic [CNT_W-1:0]  delay
);
  logic [FRAC_BITS-1:0] frac_q;
  q4_t                  base;
  q4_t                  sum;

  always_comb begin
    base  = preload ? q4_t'(BLANK_PRELOAD_Q4) : q4_t'(frac_q);
    sum   = period_add(base, 32'(line_cfg), LINE_Q4);
    delay = CNT_W'(whole_part(sum));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     frac_q <= '0;
    else if (sched) frac_q <= sum[FRAC_BITS-1:0];
  end
endmodule

// File: rtl/lis_counter.sv
module lis_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sched,
  input  logic             stop,
  input  logic [CNT_W-1:0] load,
  output logic [CNT_W-1:0] cnt,
  output logic             armed,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = tick & armed & (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (sched) begin
      cnt   <= load;
      armed <= 1'b1;
    end else if (stop) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (tick && armed) begin
      cnt   <= cnt - ONE;
    end
  end
endmodule

// File: rtl/line_irq_sched.sv
module line_irq_sched #(
  parameter int LINE_W  = 8,
  parameter int LINE_Q4 = 7816,
  localparam int CNT_W  = $clog2(((((2 ** LINE_W) * LINE_Q4)) >> 4) + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_cfg,
  input  logic              vblank_end,
  input  logic              hint_in_vblank,
  input  logic              vblank,
  input  logic              tick,
  output logic              irq,
  output logic [CNT_W-1:0]  countdown
);
  logic             preload;
  logic             sched;
  logic             stop;
  logic             armed;
  logic             expire;
  logic [CNT_W-1:0] delay;

  lis_ctrl u_ctrl (
    .vblank_end     (vblank_end),
    .hint_in_vblank (hint_in_vblank),
    .vblank         (vblank),
    .armed          (armed),
    .expire         (expire),
    .preload        (preload),
    .sched          (sched),
    .stop           (stop)
  );

  lis_accum #(.LINE_W(LINE_W), .LINE_Q4(LINE_Q4), .CNT_W(CNT_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .sched    (sched),
    .preload  (preload),
    .line_cfg (line_cfg),
    .delay    (delay)
  );

  lis_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .sched  (sched),
    .stop   (stop),
    .load   (delay),
    .cnt    (countdown),
    .armed  (armed),
    .expire (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= expire;
  end
endmodule

// File: rtl/line_irq_sched_chk.sv
module line_irq_sched_chk #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             vblank_end,
  input logic             hint_in_vblank,
  input logic             vblank,
  input logic             irq,
  input logic [CNT_W-1:0] countdown,
  input logic             sched
);
  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(tick) && $past(countdown) == CNT_W'(1)));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && countdown > CNT_W'(1) && !vblank_end) |=> countdown == $past(countdown) - CNT_W'(1));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !vblank_end) |=> $stable(countdown));

  // R4
  preload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_end && !hint_in_vblank) |=> countdown != '0);

  // R2
  sched_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sched |=> countdown != '0);

  // R8
  suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && countdown == CNT_W'(1) && !vblank_end && !hint_in_vblank && vblank)
      |=> (irq && countdown == '0));
endmodule

bind line_irq_sched line_irq_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick           (tick),
  .vblank_end     (vblank_end),
  .hint_in_vblank (hint_in_vblank),
  .vblank         (vblank),
  .irq            (irq),
  .countdown      (countdown),
  .sched          (sched)
);

// File: tb/sim_line_irq_sched.sv
`timescale 1ns/1ps
module sim_line_irq_sched;
  localparam int LINE_W = 8;
  localparam int CNT_W  = 17;
  localparam int Q4_LINE = 7816; // 488.5 * 16

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [LINE_W-1:0] line_cfg = '0;
  logic              vblank_end = 1'b0;
  logic              hint_in_vblank = 1'b0;
  logic              vblank = 1'b0;
  logic              tick = 1'b0;
  logic              irq;
  logic [CNT_W-1:0]  countdown;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int m_frac = 0;
  int m_cnt  = 0;
  bit m_arm  = 0;
  bit m_irq  = 0;

  always #2.5 clk = ~clk;

  line_irq_sched u0 (
    .clk(clk), .rst_n(rst_n), .line_cfg(line_cfg), .vblank_end(vblank_end),
    .hint_in_vblank(hint_in_vblank), .vblank(vblank), .tick(tick),
    .irq(irq), .countdown(countdown)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Period in whole cycles and new residue, from the requirement text
  function automatic int load_of(input int base, input int lines_m1);
    int s;
    s = base + (lines_m1 + 1) * Q4_LINE;
    return s / 16;
  endfunction
  function automatic int resid_of(input int base, input int lines_m1);
    int s;
    s = base + (lines_m1 + 1) * Q4_LINE;
    return s - 16 * (s / 16);
  endfunction

  task automatic model_step(input bit t, input bit vbe, input bit alw, input bit vb);
    bit fire, pre, start, resched;
    int base;
    fire    = t && m_arm && (m_cnt == 1);
    pre     = vbe && !alw;
    start   = vbe && alw && !m_arm;
    resched = pre || start || (fire && (alw || !vb));
    if (resched) begin
      base   = pre ? -24 : m_frac;
      m_cnt  = load_of(base, int'(line_cfg));
      m_frac = resid_of(base, int'(line_cfg));
      m_arm  = 1;
    end else if (fire) begin
      m_arm = 0;
      m_cnt = 0;
    end else if (t && m_arm) begin
      m_cnt = m_cnt - 1;
    end
    m_irq = fire;
  endtask

  task automatic cyc(input bit t, input bit vbe, input bit alw, input bit vb, input string tag);
    @(negedge clk);
    tick = t; vblank_end = vbe; hint_in_vblank = alw; vblank = vb;
    model_step(t, vbe, alw, vb);
    @(posedge clk);
    #1;
    chk({tag, " irq"}, longint'(irq), longint'(m_irq));
    chk({tag, " countdown"}, longint'(countdown), longint'(m_cnt));
  endtask

  task automatic run_to_fire(input bit alw, input bit vb, input string tag);
    while (m_cnt > 1) cyc(1, 0, alw, vb, tag);
    cyc(1, 0, alw, vb, tag);
  endtask

  initial begin
    #(190000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int prev;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset irq", longint'(irq), 0);
    chk("R1 reset countdown", longint'(countdown), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: ticks alone do nothing
    repeat (10) cyc(1, 0, 0, 0, "R1 idle");
    chk("R1 still idle", longint'(countdown), 0);

    // R4: blank-end restart, line_cfg = 0 -> 487
    line_cfg = 8'd0;
    cyc(1, 1, 0, 0, "R4 preload");
    chk("R4 first period", longint'(countdown), 487);

    // R6: hold and decrement
    repeat (3) cyc(0, 0, 0, 0, "R6 hold");
    chk("R6 held", longint'(countdown), 487);
    repeat (5) cyc(1, 0, 0, 0, "R6 step");
    chk("R6 stepped", longint'(countdown), 482);

    // R9: change mid-count has no effect now
    line_cfg = 8'd5;
    cyc(1, 0, 0, 0, "R9 midcount");
    chk("R9 unaffected", longint'(countdown), 481);

    // R7: expiry pulses and reloads with 6 lines: 46896/16 = 2931
    run_to_fire(0, 0, "R7 run");
    chk("R7 pulse", longint'(irq), 1);
    chk("R9 new cfg used", longint'(countdown), 2931);
    cyc(1, 0, 0, 0, "R7 single");
    chk("R7 pulse ends", longint'(irq), 0);

    // R3: alternation 488 / 489
    line_cfg = 8'd0;
    run_to_fire(0, 0, "R3 run");
    chk("R3 period a", longint'(countdown), 488);
    run_to_fire(0, 0, "R3 run");
    chk("R3 period b", longint'(countdown), 489);

    // R5: allowed-in-blank strobe ignored while running
    repeat (4) cyc(1, 0, 1, 0, "R5 run");
    prev = int'(countdown);
    cyc(1, 1, 1, 0, "R5 ignored");
    chk("R5 no restart", longint'(countdown), longint'(prev - 1));

    // R8: suppressed expiry
    run_to_fire(0, 1, "R8 run");
    chk("R8 pulse", longint'(irq), 1);
    chk("R8 idle", longint'(countdown), 0);
    repeat (600) cyc(1, 0, 0, 1, "R8 quiet");
    chk("R8 no pulse", longint'(irq), 0);
    chk("R8 still idle", longint'(countdown), 0);

    // R5: idle start from residue 0 without offset -> 488
    cyc(1, 1, 1, 0, "R5 idle start");
    chk("R5 started", longint'(countdown), 488);

    // R4: restart discards residue 8; two lines -> 15608/16 = 975
    line_cfg = 8'd1;
    cyc(1, 1, 0, 0, "R4 restart");
    chk("R4 residue dropped", longint'(countdown), 975);

    // R2: randomized run against the model
    for (int i = 0; i < 40000; i++) begin
      bit t, vbe, alw, vb;
      if (i % 700 == 0) line_cfg = LINE_W'($urandom % 4);
      t   = ($urandom % 4) != 0;
      vbe = ($urandom % 2500) == 0;
      alw = ((i / 5000) % 3) == 1;
      vb  = (i % 3000) > 2700;
      cyc(t, vbe, alw, vb, "R2 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule